// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Controller

This block sits in line on the shared system bus, between the initiators (CPU and DMA, already merged onto one request channel) and the targets behind the bus. It holds one global reservation: a valid flag and the upper address bits of a naturally aligned power-of-two granule. A load-reserved (LR) request records its granule and is forwarded to the target as a read. A store-conditional (SC) request is forwarded as a write only when the reservation is valid and the address falls in the reserved granule. Any other SC is answered locally by the controller and never reaches the target.

Every SC returns a status in bit 0 of the response data, 0 for success and 1 for failure. Ordinary stores that land in the reserved granule clear the reservation, so a conflicting write from any initiator makes the next SC fail. Nothing except an LR, an SC, a conflicting store or hardware reset changes the reservation. Bus errors have defined outcomes: an LR that errors keeps its reservation, and an SC that errors still clears it.

Top module: `rsv_ctrl`

## Requirements
- R1: An LR request (type code 2'b01) is forwarded as a read (dn_we_o = 0) and sets the reservation to its granule, replacing any earlier reservation.
- R2: The granule is GRANULE_BYTES wide (a power of two, at least 4, default 4) and naturally aligned; an address hits when its bits above log2(GRANULE_BYTES) equal the stored ones, so byte offsets inside the granule all hit.
- R3: Every SC request (type code 2'b10) clears the reservation, whether it succeeds or fails.
- R4: An SC with a valid reservation and a granule hit is forwarded as a write (dn_we_o = 1), and its response carries status 0 in bit 0 of up_rdata_o.
- R5: An SC without a valid hitting reservation is not forwarded (dn_req_o stays 0); the controller acknowledges it one cycle after the request with bit 0 of up_rdata_o = 1 and up_err_o = 0.
- R6: An ordinary write (type 2'b00 or 2'b11 with up_we_i = 1) into the reserved granule clears the reservation; ordinary reads and writes outside the granule leave it intact.
- R7: An LR that ends in a bus error still leaves the reservation set; a forwarded SC that ends in a bus error still clears it and reports status 1 together with up_err_o.
- R8: Hardware reset clears the reservation and any outstanding response; after reset dn_req_o and up_ack_o are 0 and a first SC fails.
- R9: Ordinary transactions pass to the target unchanged (address, write flag, data, byte enables), and the target's read data, acknowledge and error return unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released in step with the clock |
| up_req_i | input | 1 | One-cycle request strobe from the initiator side |
| up_type_i | input | 2 | Access type: 00 ordinary, 01 LR, 10 SC, 11 ordinary |
| up_addr_i | input | ADDR_W | Byte address |
| up_we_i | input | 1 | Write flag for ordinary accesses |
| up_wdata_i | input | DATA_W | Write data |
| up_be_i | input | DATA_W/8 | Byte enables |
| up_rdata_o | output | DATA_W | Response data; bit 0 is the SC status for SC responses |
| up_ack_o | output | 1 | Response strobe |
| up_err_o | output | 1 | Response error |
| dn_req_o | output | 1 | Request strobe to the target |
| dn_addr_o | output | ADDR_W | Address to the target |
| dn_we_o | output | 1 | Write flag to the target |
| dn_wdata_o | output | DATA_W | Write data to the target |
| dn_be_o | output | DATA_W/8 | Byte enables to the target |
| dn_rdata_i | input | DATA_W | Target read data |
| dn_ack_i | input | 1 | Target acknowledge |
| dn_err_i | input | 1 | Target error |

## Verification
The assertions take for granted that the initiator side keeps at most one transaction outstanding: no new request strobe arrives while a response is pending, and the target acknowledges only a forwarded request. One of the assertions checks the first condition against the controller's own pending state. The bench keeps within this by having its driver wait for the scoreboard queue to drain before it issues the next request, while its target model answers each forwarded request exactly once after a chosen latency.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  typedef enum logic [1:0] {
    ACC_PLAIN = 2'b00,
    ACC_LR    = 2'b01,
    ACC_SC    = 2'b10,
    ACC_ALT   = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    PND_IDLE  = 2'b00,
    PND_PLAIN = 2'b01,
    PND_SC    = 2'b10,
    PND_LOCAL = 2'b11
  } pnd_e;

endpackage

// File: rtl/rsv_match.sv
module rsv_match #(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 2,
  localparam int TAG_W   = ADDR_W - GRAN_LSB
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic [TAG_W-1:0]  addr_tag_o,
  output logic              hit_o
);

  // Offset bits inside the granule never take part in the compare.
  always_comb begin
    addr_tag_o = addr_i[ADDR_W-1:GRAN_LSB];
    hit_o      = (addr_tag_o == tag_i);
  end

endmodule

// File: rtl/rsv_track.sv
module rsv_track #(
  parameter int TAG_W = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o
);

  logic             valid_q, valid_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             tag_en;

  always_comb begin
    valid_d = valid_q;
    tag_en  = 1'b0;
    tag_d   = tag_q;
    if (set_i) begin
      valid_d = 1'b1;
      tag_en  = 1'b1;
      tag_d   = tag_i;
    end else if (clr_i) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= '0;
    end else if (tag_en) begin
      tag_q <= tag_d;
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;

  AST_LR_SETS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> valid_o) else $error("LR did not set reservation"); // R1

  AST_CLEAR_DROPS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !valid_o) else $error("clear did not drop reservation"); // R3

endmodule

// File: rtl/rsv_resp.sv
module rsv_resp
  import rsv_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_plain_i,
  input  logic              start_sc_i,
  input  logic              start_local_i,
  input  logic [DATA_W-1:0] dn_rdata_i,
  input  logic              dn_ack_i,
  input  logic              dn_err_i,
  output logic [DATA_W-1:0] up_rdata_o,
  output logic              up_ack_o,
  output logic              up_err_o
);

  pnd_e state_q, state_d;
  logic fwd_wait;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PND_IDLE: begin
        if (start_local_i)      state_d = PND_LOCAL;
        else if (start_sc_i)    state_d = PND_SC;
        else if (start_plain_i) state_d = PND_PLAIN;
      end
      PND_PLAIN, PND_SC: begin
        if (dn_ack_i) state_d = PND_IDLE;
      end
      PND_LOCAL: state_d = PND_IDLE;
      default:   state_d = PND_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PND_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    fwd_wait   = (state_q == PND_PLAIN) || (state_q == PND_SC);
    up_ack_o   = (state_q == PND_LOCAL) || (fwd_wait && dn_ack_i);
    up_err_o   = fwd_wait && dn_ack_i && dn_err_i;
    up_rdata_o = dn_rdata_i;
    if (state_q == PND_LOCAL) begin
      up_rdata_o = {{(DATA_W-1){1'b0}}, 1'b1};
    end else if (state_q == PND_SC) begin
      up_rdata_o = {{(DATA_W-1){1'b0}}, dn_err_i};
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != PND_IDLE) |-> !(start_plain_i || start_sc_i || start_local_i))
    else $error("request while a response is pending"); // R9

  AST_LOCAL_ACK_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_local_i |=> (up_ack_o && !up_err_o && up_rdata_o[0]))
    else $error("local SC answer malformed"); // R5

endmodule

// File: rtl/rsv_ctrl.sv
module rsv_ctrl
  import rsv_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int DATA_W        = 32,
  parameter int GRANULE_BYTES = 4,
  localparam int BE_W         = DATA_W / 8,
  localparam int GRAN_LSB     = $clog2(GRANULE_BYTES),
  localparam int TAG_W        = ADDR_W - GRAN_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              up_req_i,
  input  logic [1:0]        up_type_i,
  input  logic [ADDR_W-1:0] up_addr_i,
  input  logic              up_we_i,
  input  logic [DATA_W-1:0] up_wdata_i,
  input  logic [BE_W-1:0]   up_be_i,
  output logic [DATA_W-1:0] up_rdata_o,
  output logic              up_ack_o,
  output logic              up_err_o,
  output logic              dn_req_o,
  output logic [ADDR_W-1:0] dn_addr_o,
  output logic              dn_we_o,
  output logic [DATA_W-1:0] dn_wdata_o,
  output logic [BE_W-1:0]   dn_be_o,
  input  logic [DATA_W-1:0] dn_rdata_i,
  input  logic              dn_ack_i,
  input  logic              dn_err_i
);

  logic             rsv_valid;
  logic [TAG_W-1:0] rsv_tag;
  logic [TAG_W-1:0] req_tag;
  logic             tag_hit;
  logic             is_lr, is_sc, is_store, sc_ok, store_hit;
  logic             rsv_set, rsv_clr;
  logic             start_plain, start_sc, start_local;

  rsv_match #(
    .ADDR_W   (ADDR_W),
    .GRAN_LSB (GRAN_LSB)
  ) u_match (
    .addr_i     (up_addr_i),
    .tag_i      (rsv_tag),
    .addr_tag_o (req_tag),
    .hit_o      (tag_hit)
  );

  rsv_track #(
    .TAG_W (TAG_W)
  ) u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (rsv_set),
    .clr_i   (rsv_clr),
    .tag_i   (req_tag),
    .valid_o (rsv_valid),
    .tag_o   (rsv_tag)
  );

  // Request decode; 2'b11 is treated as an ordinary access.
  always_comb begin
    is_lr     = up_req_i && (up_type_i == ACC_LR);
    is_sc     = up_req_i && (up_type_i == ACC_SC);
    is_store  = up_req_i && up_we_i &&
                ((up_type_i == ACC_PLAIN) || (up_type_i == ACC_ALT));
    sc_ok     = is_sc && rsv_valid && tag_hit;
    store_hit = is_store && rsv_valid && tag_hit;
    rsv_set   = is_lr;
    rsv_clr   = is_sc || store_hit;
  end

  // Forward path to the target.
  always_comb begin
    dn_req_o   = up_req_i && (!is_sc || sc_ok);
    dn_addr_o  = up_addr_i;
    dn_wdata_o = up_wdata_i;
    dn_be_o    = up_be_i;
    if (is_sc)      dn_we_o = 1'b1;
    else if (is_lr) dn_we_o = 1'b0;
    else            dn_we_o = up_we_i;
    start_plain = up_req_i && !is_sc;
    start_sc    = sc_ok;
    start_local = is_sc && !sc_ok;
  end

  rsv_resp #(
    .DATA_W (DATA_W)
  ) u_resp (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_plain_i (start_plain),
    .start_sc_i    (start_sc),
    .start_local_i (start_local),
    .dn_rdata_i    (dn_rdata_i),
    .dn_ack_i      (dn_ack_i),
    .dn_err_i      (dn_err_i),
    .up_rdata_o    (up_rdata_o),
    .up_ack_o      (up_ack_o),
    .up_err_o      (up_err_o)
  );

  AST_NO_FWD_WITHOUT_RSV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_sc && !rsv_valid) |-> !dn_req_o) else $error("SC forwarded without reservation"); // R5

  AST_SC_FAIL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_sc && !dn_req_o) |=> (up_ack_o && up_rdata_o[0])) else $error("failed SC not acknowledged"); // R5

  AST_SC_ALWAYS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_sc |=> !rsv_valid) else $error("SC left reservation set"); // R3

endmodule

// File: tb/rsv_ctrl_tb_top.sv
module rsv_ctrl_tb_top;

  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic          up_req;
  logic [1:0]    up_type;
  logic [AW-1:0] up_addr;
  logic          up_we;
  logic [DW-1:0] up_wdata;
  logic [3:0]    up_be;
  logic [DW-1:0] up_rdata;
  logic          up_ack, up_err;
  logic          dn_req;
  logic [AW-1:0] dn_addr;
  logic          dn_we;
  logic [DW-1:0] dn_wdata;
  logic [3:0]    dn_be;
  logic [DW-1:0] dn_rdata;
  logic          dn_ack, dn_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct {
    logic [DW-1:0] rdata;
    logic          err;
    string         req;
  } exp_t;
  exp_t sb_q[$];

  // target model knobs
  int   tgt_lat = 1;
  logic tgt_err = 1'b0;
  int   tgt_cnt;
  logic [AW-1:0] tgt_addr;
  logic          tgt_we;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  rsv_ctrl dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .up_req_i   (up_req),
    .up_type_i  (up_type),
    .up_addr_i  (up_addr),
    .up_we_i    (up_we),
    .up_wdata_i (up_wdata),
    .up_be_i    (up_be),
    .up_rdata_o (up_rdata),
    .up_ack_o   (up_ack),
    .up_err_o   (up_err),
    .dn_req_o   (dn_req),
    .dn_addr_o  (dn_addr),
    .dn_we_o    (dn_we),
    .dn_wdata_o (dn_wdata),
    .dn_be_o    (dn_be),
    .dn_rdata_i (dn_rdata),
    .dn_ack_i   (dn_ack),
    .dn_err_i   (dn_err)
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {a[31:2], 2'b00} ^ 32'hA5A5_0000;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  // Target: answers each forwarded request once after tgt_lat edges.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_cnt  <= 0;
      dn_ack   <= 1'b0;
      dn_err   <= 1'b0;
      dn_rdata <= '0;
      tgt_addr <= '0;
      tgt_we   <= 1'b0;
    end else begin
      dn_ack <= 1'b0;
      dn_err <= 1'b0;
      if (tgt_cnt != 0) begin
        tgt_cnt <= tgt_cnt - 1;
        if (tgt_cnt == 1) begin
          dn_ack   <= 1'b1;
          dn_err   <= tgt_err;
          dn_rdata <= tgt_we ? '0 : mem_word(tgt_addr);
        end
      end else if (dn_req) begin
        if (tgt_lat <= 1) begin
          dn_ack   <= 1'b1;
          dn_err   <= tgt_err;
          dn_rdata <= dn_we ? '0 : mem_word(dn_addr);
        end else begin
          tgt_cnt  <= tgt_lat - 1;
          tgt_addr <= dn_addr;
          tgt_we   <= dn_we;
        end
      end
    end
  end

  // Monitor: pops the scoreboard on each response.
  always @(negedge clk) begin
    if (rst_n && up_ack) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R9", "unexpected ack", {31'b0, up_ack}, '0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(up_rdata == e.rdata, e.req, "rdata", up_rdata, e.rdata);
        check(up_err == e.err, e.req, "err", {31'b0, up_err}, {31'b0, e.err});
      end
    end
  end

  // Driver: one request, checks the forward decision, queues the expected response.
  task automatic txn(input logic [1:0] typ, input logic [AW-1:0] a, input logic we,
                     input bit exp_fwd, input logic exp_dn_we,
                     input logic [DW-1:0] exp_rdata, input logic exp_err,
                     input string req);
    exp_t e;
    @(negedge clk);
    up_req   = 1'b1;
    up_type  = typ;
    up_addr  = a;
    up_we    = we;
    up_wdata = a ^ 32'h1234_5678;
    up_be    = 4'b1011;
    #1;
    check(dn_req == exp_fwd, req, "dn_req", {31'b0, dn_req}, {31'b0, exp_fwd});
    if (exp_fwd) begin
      check(dn_we == exp_dn_we, req, "dn_we", {31'b0, dn_we}, {31'b0, exp_dn_we});
      check((dn_addr == a) && (dn_wdata == (a ^ 32'h1234_5678)) && (dn_be == 4'b1011),
            req, "forwarded fields", dn_addr, a);
    end
    e.rdata = exp_rdata;
    e.err   = exp_err;
    e.req   = req;
    sb_q.push_back(e);
    @(negedge clk);
    up_req = 1'b0;
    for (int i = 0; i < 20 && sb_q.size() != 0; i++) @(negedge clk);
    if (sb_q.size() != 0) begin
      check(1'b0, req, "no response", '0, 32'h1);
      sb_q.delete();
    end
  endtask

  localparam logic [1:0] T_PL = 2'b00;
  localparam logic [1:0] T_LR = 2'b01;
  localparam logic [1:0] T_SC = 2'b10;
  localparam logic [1:0] T_AL = 2'b11;
  localparam logic [DW-1:0] ST_OK  = 32'h0;
  localparam logic [DW-1:0] ST_BAD = 32'h1;

  initial begin
    rst_n = 1'b0; up_req = 1'b0; up_type = '0; up_addr = '0;
    up_we = 1'b0; up_wdata = '0; up_be = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(!dn_req && !up_ack, "R8", "outputs in reset", {30'b0, dn_req, up_ack}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!dn_req && !up_ack, "R8", "outputs after reset", {30'b0, dn_req, up_ack}, '0);

    // R8/R5: SC right after reset fails locally
    txn(T_SC, 32'h100, 1'b0, 0, 1'b1, ST_BAD, 1'b0, "R8");
    // R1: LR forwarded as read with target data
    txn(T_LR, 32'h100, 1'b1, 1, 1'b0, mem_word(32'h100), 1'b0, "R1");
    // R2/R4: SC at another byte of the same granule succeeds
    txn(T_SC, 32'h102, 1'b0, 1, 1'b1, ST_OK, 1'b0, "R4");
    // R3: reservation consumed, repeat SC fails
    txn(T_SC, 32'h100, 1'b0, 0, 1'b1, ST_BAD, 1'b0, "R3");

    // R6/R9: reads and outside stores keep the reservation
    txn(T_LR, 32'h200, 1'b0, 1, 1'b0, mem_word(32'h200), 1'b0, "R1");
    txn(T_PL, 32'h200, 1'b0, 1, 1'b0, mem_word(32'h200), 1'b0, "R9");
    txn(T_PL, 32'h204, 1'b1, 1, 1'b1, 32'h0, 1'b0, "R9");
    txn(T_AL, 32'h1FC, 1'b1, 1, 1'b1, 32'h0, 1'b0, "R6");
    txn(T_SC, 32'h200, 1'b0, 1, 1'b1, ST_OK, 1'b0, "R6");

    // R1: a new LR replaces the older reservation
    txn(T_LR, 32'h300, 1'b0, 1, 1'b0, mem_word(32'h300), 1'b0, "R1");
    txn(T_LR, 32'h400, 1'b0, 1, 1'b0, mem_word(32'h400), 1'b0, "R1");
    txn(T_SC, 32'h300, 1'b0, 0, 1'b1, ST_BAD, 1'b0, "R1");

    // R2: SC in the neighbouring granule fails
    txn(T_LR, 32'h480, 1'b0, 1, 1'b0, mem_word(32'h480), 1'b0, "R2");
    txn(T_SC, 32'h484, 1'b0, 0, 1'b1, ST_BAD, 1'b0, "R2");

    // R6: ordinary store into the granule (type 11) clears it
    txn(T_LR, 32'h500, 1'b0, 1, 1'b0, mem_word(32'h500), 1'b0, "R6");
    txn(T_AL, 32'h501, 1'b1, 1, 1'b1, 32'h0, 1'b0, "R6");
    txn(T_SC, 32'h500, 1'b0, 0, 1'b1, ST_BAD, 1'b0, "R6");

    // R7: LR with error keeps the reservation
    tgt_err = 1'b1;
    txn(T_LR, 32'h600, 1'b0, 1, 1'b0, mem_word(32'h600), 1'b1, "R7");
    tgt_err = 1'b0;
    txn(T_SC, 32'h600, 1'b0, 1, 1'b1, ST_OK, 1'b0, "R7");

    // R7: SC with error reports status 1 and still clears
    txn(T_LR, 32'h700, 1'b0, 1, 1'b0, mem_word(32'h700), 1'b0, "R7");
    tgt_err = 1'b1;
    txn(T_SC, 32'h700, 1'b0, 1, 1'b1, ST_BAD, 1'b1, "R7");
    tgt_err = 1'b0;
    txn(T_SC, 32'h700, 1'b0, 0, 1'b1, ST_BAD, 1'b0, "R7");

    // R9: slow target, data and error pass through
    tgt_lat = 3;
    txn(T_PL, 32'hABC0, 1'b0, 1, 1'b0, mem_word(32'hABC0), 1'b0, "R9");
    tgt_err = 1'b1;
    txn(T_PL, 32'hABC4, 1'b1, 1, 1'b1, 32'h0, 1'b1, "R9");
    tgt_err = 1'b0;
    txn(T_LR, 32'h880, 1'b0, 1, 1'b0, mem_word(32'h880), 1'b0, "R1");
    txn(T_SC, 32'h880, 1'b0, 1, 1'b1, ST_OK, 1'b0, "R4");
    tgt_lat = 1;

    // R8: reset drops the reservation
    txn(T_LR, 32'h800, 1'b0, 1, 1'b0, mem_word(32'h800), 1'b0, "R8");
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    txn(T_SC, 32'h800, 1'b0, 0, 1'b1, ST_BAD, 1'b0, "R8");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule